// File: doc/BRIEF.md
# Byte-Wide Configuration Store with Stall Input

This block is a read-only store that streams a configuration image to a configuration target over an 8-bit bus. The target supplies a free-running clock. The target captures the word shown on the bus at each rising edge, and the same edge moves the store to its next position. The store does not count the image length. It turns its bus off and pulls its cascade output low once the last location has been delivered, so a following store in a chain can take over. A parameter picks one of two bus shapes. In byte mode the whole word goes out on bits 7..0. In serial mode only bit 0 carries data, one bit per clock.

The target can pause the stream with a stall input. On an edge where the stall is high, nothing advances and the word on the bus stays as it was. A build option ties the stall off inside the block, for boards that leave that pin unconnected. A chip-enable input and a combined reset/output-enable input, whose active level is a parameter, gate the stream. The reset input also sends the read position back to the start. The image contents are computed from the address and a seed parameter, so no load path is needed.

Top module: `cfg_byte_store`

## Requirements
- R1: While the reset/output-enable pin is at its active level, `data_oe` is 0 and `ceo_n` is 1. After at least one rising edge with that pin active, the next word presented is location 0.
- R2: While `ce_n` is 1, `data_oe` is 0, `ceo_n` is 1, and the read position does not move. When `ce_n` returns to 0, the stream resumes at the same word, with none skipped.
- R3: In byte mode (`OUT_MODE` = byte), an active store drives all 8 bits (`data_oe` = 8'hFF). Every rising edge with `ce_n`=0, reset inactive and stall low moves to the next location.
- R4: A rising edge that samples `busy`=1 advances nothing. The word on the bus is unchanged after that edge, and the stream resumes with that same word once `busy` returns low.
- R5: With `IGNORE_BUSY`=1 the `busy` pin has no effect, and the stream runs at one step per clock whatever `busy` does.
- R6: After the edge that consumes the last location (address `DEPTH`-1), `data_oe` is 0. From then on `ceo_n` equals `ce_n` until the pin reset is applied, and the read position stays at the end.
- R7: In serial mode, `data_oe` = 8'h01 and bits 7..1 are never driven. Each word goes out on `data_o[0]`, most significant bit first, and the address advances after the eighth bit. In either mode `data_oe` is only ever 0 or the full mode mask.
- R8: Location a holds ((a mod 256)·37 + `SEED`) mod 256.
- R9: A pin reset applied in the middle of the stream, or after the end, clears the end state. The stream then restarts from location 0.
- R10: `RST_ACTIVE_HIGH` selects the active level of `rst_oe`: 1 means a high level resets, 0 means a low level resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, free-running, rising edge |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| rst_oe | input | 1 | Combined reset/output enable, level set by `RST_ACTIVE_HIGH` |
| ce_n | input | 1 | Chip enable, active low |
| busy | input | 1 | Stall request from the target, active high |
| data_o | output | 8 | Word presented to the target (bit 0 only in serial mode) |
| data_oe | output | 8 | Per-bit drive enable for `data_o`; 0 means not driven |
| ceo_n | output | 1 | Cascade enable to the next store, active low |

## Verification
A stall can land on the same edge as the last location, or on an edge just before a chip-enable drop or a pin reset. In those cases the hold logic and the end-of-image or restart logic act at the same time. The bench toggles `busy` at random on every cycle, including across the final word and across chip-enable pauses and reset pulses. A scoreboard of expected words is compared to every word captured while the bus is driven and the stall is low. Any word dropped, repeated or left over after the end shows up as a mismatch, and the cascade output is then checked for the end state.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = 3;

  typedef enum logic {
    OUT_BYTE   = 1'b0,
    OUT_SERIAL = 1'b1
  } out_mode_e;

  // Contents of one location, derived from its address and a seed.
  function automatic logic [BYTE_W-1:0] cell_value(input logic [31:0] addr,
                                                   input logic [BYTE_W-1:0] seed);
    logic [BYTE_W-1:0] lo;
    lo = addr[BYTE_W-1:0];
    return BYTE_W'(lo * 8'd37) + seed;
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_addr_seq.sv
module cfg_addr_seq
  import cfg_store_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter bit SERIAL = 1'b0,
  localparam int ADDR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 run,
  input  logic                 hold,
  output logic [ADDR_W-1:0]    addr,
  output logic [BIT_IDX_W-1:0] bit_idx,
  output logic                 done
);

  localparam logic [ADDR_W-1:0]    LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT  = '1;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              step;
  logic              word_end;

  assign step = run & ~hold & ~done_q;

  generate
    if (SERIAL) begin : g_bitcnt
      logic [BIT_IDX_W-1:0] bit_q, bit_d;

      always_comb begin
        bit_d = bit_q;
        if (clr) begin
          bit_d = '0;
        end else if (step) begin
          bit_d = bit_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= '0;
        end else begin
          bit_q <= bit_d;
        end
      end

      assign word_end = (bit_q == LAST_BIT);
      assign bit_idx  = bit_q;
    end else begin : g_nobitcnt
      assign word_end = 1'b1;
      assign bit_idx  = '0;
    end
  endgenerate

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    if (clr) begin
      addr_d = '0;
      done_d = 1'b0;
    end else if (step && word_end) begin
      if (addr_q == LAST_ADDR) begin
        done_d = 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr = addr_q;
  assign done = done_q;

endmodule

// File: rtl/cfg_cell_rom.sv
module cfg_cell_rom
  import cfg_store_pkg::*;
#(
  parameter int               ADDR_W = 6,
  parameter logic [BYTE_W-1:0] SEED  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] word
);

  always_comb begin
    word = cell_value(32'(addr), SEED);
  end

endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
  import cfg_store_pkg::*;
#(
  parameter bit SERIAL = 1'b0
) (
  input  logic [BYTE_W-1:0]    word,
  input  logic [BIT_IDX_W-1:0] bit_idx,
  input  logic                 rst_act,
  input  logic                 ce_act,
  input  logic                 done,
  output logic [BYTE_W-1:0]    data_o,
  output logic [BYTE_W-1:0]    data_oe,
  output logic                 ceo_n
);

  localparam logic [BYTE_W-1:0] LANE_MASK = SERIAL ? BYTE_W'(1) : '1;

  logic                 enabled;
  logic                 drive;
  logic                 serial_bit;
  logic [BIT_IDX_W-1:0] msb_first_idx;

  assign enabled       = ce_act & ~rst_act;
  assign drive         = enabled & ~done;
  assign msb_first_idx = ~bit_idx;
  assign serial_bit    = word[msb_first_idx];

  always_comb begin
    data_o  = SERIAL ? {{(BYTE_W-1){1'b0}}, serial_bit} : word;
    data_oe = drive ? LANE_MASK : '0;
    ceo_n   = ~(enabled & done);
  end

endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
  import cfg_store_pkg::*;
#(
  parameter int                DEPTH           = 64,
  parameter logic [BYTE_W-1:0] SEED            = 8'h00,
  parameter out_mode_e         OUT_MODE        = OUT_BYTE,
  parameter bit                RST_ACTIVE_HIGH = 1'b0,
  parameter bit                IGNORE_BUSY     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_oe,
  input  logic              ce_n,
  input  logic              busy,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] data_oe,
  output logic              ceo_n
);

  localparam bit SERIAL = (OUT_MODE == OUT_SERIAL);
  localparam int ADDR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic                 rst_int_n;
  logic                 rst_act;
  logic                 ce_act;
  logic                 hold;
  logic [ADDR_W-1:0]    addr;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic                 done;
  logic [BYTE_W-1:0]    word;

  assign rst_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;
  assign ce_act  = ~ce_n;
  assign hold    = busy & ~IGNORE_BUSY;

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cfg_addr_seq #(.DEPTH(DEPTH), .SERIAL(SERIAL)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (rst_act),
    .run     (ce_act),
    .hold    (hold),
    .addr    (addr),
    .bit_idx (bit_idx),
    .done    (done)
  );

  cfg_cell_rom #(.ADDR_W(ADDR_W), .SEED(SEED)) u_rom (
    .addr (addr),
    .word (word)
  );

  cfg_out_stage #(.SERIAL(SERIAL)) u_out (
    .word    (word),
    .bit_idx (bit_idx),
    .rst_act (rst_act),
    .ce_act  (ce_act),
    .done    (done),
    .data_o  (data_o),
    .data_oe (data_oe),
    .ceo_n   (ceo_n)
  );

endmodule

// File: rtl/cfg_byte_store_chk.sv
module cfg_byte_store_chk
  import cfg_store_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SEED            = 8'h00,
  parameter bit                SERIAL          = 1'b0,
  parameter bit                RST_ACTIVE_HIGH = 1'b0,
  parameter bit                IGNORE_BUSY     = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_oe,
  input logic              ce_n,
  input logic              busy,
  input logic [BYTE_W-1:0] data_o,
  input logic [BYTE_W-1:0] data_oe,
  input logic              ceo_n
);

  localparam logic [BYTE_W-1:0] LOC0      = cell_value(32'd0, SEED);
  localparam logic [BYTE_W-1:0] FIRST_OUT = SERIAL ? {{(BYTE_W-1){1'b0}}, LOC0[BYTE_W-1]} : LOC0;
  localparam logic [BYTE_W-1:0] FULL_MASK = SERIAL ? BYTE_W'(1) : '1;

  logic pin_act;
  assign pin_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;

  // R1 / R10: reset level keeps the bus and cascade quiet
  assert_bus_off_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pin_act |-> (data_oe == '0) && ceo_n);

  // R9: an edge under reset puts location 0 on the bus
  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_act |=> (data_o == FIRST_OUT));

  // R2: disabled store does not move and keeps quiet
  assert_ce_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !pin_act) |=> $stable(data_o));
  assert_ce_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (data_oe == '0) && ceo_n);

  // R4: a sampled stall freezes the presented value
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !IGNORE_BUSY && !pin_act) |=> $stable(data_o));

  // R7: drive enable is either off or the full lane mask
  assert_oe_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe == '0) || (data_oe == FULL_MASK));

  // R6: cascade low only when own bus is off and enable is active
  assert_end_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ceo_n |-> (data_oe == '0) && !ce_n);

  // R3: in byte mode each unstalled active edge presents a new word
  generate
    if (!SERIAL) begin : g_step
      assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !pin_act && !(busy && !IGNORE_BUSY) && (data_oe != '0))
        |=> ((data_oe == '0) || (data_o != $past(data_o))));
    end
  endgenerate

endmodule

bind cfg_byte_store cfg_byte_store_chk #(
  .SEED            (SEED),
  .SERIAL          (OUT_MODE == cfg_store_pkg::OUT_SERIAL),
  .RST_ACTIVE_HIGH (RST_ACTIVE_HIGH),
  .IGNORE_BUSY     (IGNORE_BUSY)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .rst_oe  (rst_oe),
  .ce_n    (ce_n),
  .busy    (busy),
  .data_o  (data_o),
  .data_oe (data_oe),
  .ceo_n   (ceo_n)
);

// File: tb/sim_cfg_byte_store.sv
module sim_cfg_byte_store;
  import cfg_store_pkg::*;

  localparam int D0 = 40;
  localparam logic [7:0] S0 = 8'h5A;
  localparam int D1 = 6;
  localparam logic [7:0] S1 = 8'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0;
  logic rst_pin0 = 1'b0;
  logic ce0_n = 1'b1;
  logic rst_pin1 = 1'b1;
  logic ce1_n = 1'b1;
  logic [7:0] d0, oe0, d1, oe1;
  logic ceo0_n, ceo1_n;

  int checks = 0;
  int errors = 0;
  bit busy_rand = 1'b0;
  bit finished = 1'b0;
  logic [7:0] q0[$];
  logic q1[$];

  always #5 clk = ~clk;

  cfg_byte_store #(.DEPTH(D0), .SEED(S0), .OUT_MODE(OUT_BYTE),
                   .RST_ACTIVE_HIGH(1'b0), .IGNORE_BUSY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_oe(rst_pin0), .ce_n(ce0_n), .busy(busy),
    .data_o(d0), .data_oe(oe0), .ceo_n(ceo0_n));

  cfg_byte_store #(.DEPTH(D1), .SEED(S1), .OUT_MODE(OUT_SERIAL),
                   .RST_ACTIVE_HIGH(1'b1), .IGNORE_BUSY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .rst_oe(rst_pin1), .ce_n(ce1_n), .busy(busy),
    .data_o(d1), .data_oe(oe1), .ceo_n(ceo1_n));

  function automatic logic [7:0] expect_cell(int a, logic [7:0] seed);
    return 8'(((a % 256) * 37 + int'(seed)) % 256);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // stall generator, driven 2 ns after each rising edge
  always @(posedge clk) begin
    #2 busy <= busy_rand ? ($urandom_range(0, 2) == 0) : 1'b0;
  end

  // byte-mode monitor: scoreboard pop on each capturing edge (R3, R8, R4)
  logic [7:0] prev_d0 = '0;
  bit prev_hold0 = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (oe0 != 8'h00 && oe0 != 8'hFF) check(1'b0, "R3 lane mask", oe0, 8'hFF);
      if (oe0 == 8'hFF && prev_hold0) check(d0 == prev_d0, "R4 held byte", d0, prev_d0);
      if (oe0 == 8'hFF && !busy) begin
        if (q0.size() == 0) check(1'b0, "R6 extra byte", d0, 0);
        else begin
          logic [7:0] e;
          e = q0.pop_front();
          check(d0 == e, "R3/R8 byte stream", d0, e);
        end
      end
      prev_hold0 = (oe0 == 8'hFF) && busy;
      prev_d0 = d0;
    end
  end

  // serial monitor: MSB-first bits on lane 0, busy ignored (R7, R5)
  always @(negedge clk) begin
    if (rst_n && oe1 != 8'h00) begin
      check(oe1 == 8'h01, "R7 serial lane", oe1, 8'h01);
      if (q1.size() == 0) check(1'b0, "R6 extra bit", d1[0], 0);
      else begin
        logic e;
        e = q1.pop_front();
        check(d1[0] == e, "R5/R7 serial bit", d1[0], e);
      end
    end
  end

  task automatic run0(int first, int count);
    for (int a = first; a < first + count; a++) q0.push_back(expect_cell(a, S0));
    ce0_n = 1'b0;
    do begin @(negedge clk); #1; end while (q0.size() != 0);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(oe0 == 8'h00 && ceo0_n, "R1 reset quiet u0", {oe0, ceo0_n}, 9'h001);
    check(oe1 == 8'h00 && ceo1_n, "R10 active-high reset quiet u1", {oe1, ceo1_n}, 9'h001);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (3) @(posedge clk); #2;
    rst_pin0 = 1'b1;
    ce1_n = 1'b0;
    @(negedge clk);
    check(oe1 == 8'h00, "R10 high level still resets u1", oe1, 0);
    @(posedge clk); #2 ce1_n = 1'b1;
    busy_rand = 1'b1;

    run0(0, 10);
    ce0_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(oe0 == 8'h00 && ceo0_n, "R2 disabled quiet", {oe0, ceo0_n}, 9'h001);
    end
    @(posedge clk); #2;
    run0(10, 10);
    run0(20, D0 - 20);
    @(negedge clk);
    check(oe0 == 8'h00, "R6 bus off at end", oe0, 0);
    check(ceo0_n == 1'b0, "R6 cascade low at end", ceo0_n, 0);
    @(posedge clk); #2 ce0_n = 1'b1;
    @(negedge clk);
    check(ceo0_n == 1'b1, "R6 cascade follows ce", ceo0_n, 1);
    @(posedge clk); #2 ce0_n = 1'b0;
    repeat (2) @(negedge clk);
    check(ceo0_n == 1'b0 && oe0 == 8'h00, "R6 end state kept", {oe0, ceo0_n}, 0);

    @(posedge clk); #2 rst_pin0 = 1'b0;
    @(negedge clk);
    check(oe0 == 8'h00 && ceo0_n, "R9 reset clears end", {oe0, ceo0_n}, 9'h001);
    @(posedge clk); #2 rst_pin0 = 1'b1; ce0_n = 1'b1;
    @(posedge clk); #2;
    run0(0, 5);
    ce0_n = 1'b1;
    rst_pin0 = 1'b0;
    @(posedge clk); #2 rst_pin0 = 1'b1;
    run0(0, D0);
    @(negedge clk);
    check(ceo0_n == 1'b0, "R9 full rerun ends", ceo0_n, 0);
    @(posedge clk); #2 ce0_n = 1'b1;

    rst_pin1 = 1'b0;
    for (int a = 0; a < D1; a++) begin
      logic [7:0] c;
      c = expect_cell(a, S1);
      for (int b = 7; b >= 0; b--) q1.push_back(c[b]);
    end
    ce1_n = 1'b0;
    do begin @(negedge clk); #1; end while (q1.size() != 0);
    @(negedge clk);
    check(oe1 == 8'h00 && ceo1_n == 1'b0, "R6/R7 serial end", {oe1, ceo1_n}, 0);
    busy_rand = 1'b0;
    repeat (2) @(posedge clk);
    finish_up();
  end

endmodule